// File: doc/BRIEF.md
# Serial LED Shift-Register Controller

This peripheral drives a chain of external serial-in, parallel-out shift registers and provides up to 24 output-only lines. It uses three pins: a shift clock, a serial data line and a store strobe. Software programs it through a small register bus. A frame is shifted out most-significant bit first, and one store pulse then copies the shifted bits onto the parallel outputs of the chain.

An update starts in one of two ways. Software can set a request bit that clears itself, or a periodic timer can fire at one of four low rates. The timer's divider is derived from the system clock frequency parameter. Software chooses which clock edge the external registers shift on. The 16-bit lower group and the 8-bit upper group are enabled separately, and together they set the frame length. Either or both of lines 0 and 1 can take their value from hardware source inputs instead of the data register. The frame is copied into a snapshot register when an update starts, so bus writes made during a shift only apply to the next update.

Top module: `sled_shift_ctrl`

## Requirements
- R1: After reset, every register reads zero, and the shift clock, serial data and store pins are all low.
- R2: Writing 1 to bit 31 at offset 0x00 requests an update. The bit reads 1 until the update is accepted on the next idle cycle, and it reads 0 from then on.
- R3: An update shifts the frame out most-significant bit first, with one shift edge per bit. After the last bit comes a single store pulse. The value the chain latches equals the frame.
- R4: Bit 26 at offset 0x00 selects the shift edge. With 0, data shifts on the rising edge and the clock idles low. With 1, data shifts on the falling edge and the clock idles high.
- R5: Bit 0 at offset 0x04 enables data bits 15..0 (16 shifts), and bit 1 enables bits 23..16 (8 shifts). With both set, the frame is bits 23..0 (24 shifts). With neither set, a request produces no clock edge and no store pulse, but bit 31 at offset 0x00 still clears.
- R6: Bit 24 at offset 0x00 replaces line 0 with hardware input 0, and bit 25 replaces line 1 with hardware input 1. Both inputs are sampled when the update starts.
- R7: When bit 31 at offset 0x04 is set, an update is started every CLK_HZ/f system cycles. The field in bits 26..23 at offset 0x04 sets f: 0 gives 2 Hz, 1 gives 4 Hz, 2 gives 8 Hz, and 3 or above gives 10 Hz. A timer tick that arrives during a shift is dropped.
- R8: The data word at offset 0x08 (bits 23..0) is snapshotted when an update starts. A write during a shift affects only the next update.
- R9: Offsets 0x0C and 0x10 read as zero, and writes to them change nothing. Each phase of the shift clock, and the store pulse, lasts SHIFT_HALF system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| hw_src | input | 2 | Hardware sources that can override lines 1 and 0 |
| led_sclk | output | 1 | Shift clock to the chain |
| led_sdo | output | 1 | Serial data to the chain |
| led_stb | output | 1 | Store strobe to the chain |

## Verification
The assertions assume that the top level never issues a start while the serializer is busy or while no group is enabled. They also assume that serial data is stable for the whole active clock phase, and that the periodic timer is silent while its enable is off. The stimulus changes the edge, group and override settings only while the chain is idle, and it waits until the clock has settled at its new idle level before it records a baseline. Data writes during a shift are made on purpose, to show that the snapshot isolates the shift from them. Timer windows are sized so that every periodic update finishes before the next tick.

// File: rtl/sled_pkg.sv
package sled_pkg;
  localparam int LO_W  = 16;
  localparam int HI_W  = 8;
  localparam int FR_W  = LO_W + HI_W;
  localparam int HW_W  = 2;
  localparam int LEN_W = $clog2(FR_W + 1);

  typedef enum logic [1:0] {SH_IDLE, SH_SETUP, SH_ACT, SH_STORE} sh_state_t;

  function automatic int unsigned rate_hz(input logic [3:0] sel);
    case (sel)
      4'd0:    return 2;
      4'd1:    return 4;
      4'd2:    return 8;
      default: return 10;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input logic [1:0] grp);
    return (grp[0] ? LEN_W'(LO_W) : '0) + (grp[1] ? LEN_W'(HI_W) : '0);
  endfunction

  // Frame left-aligned so the first bit out is always at the top.
  function automatic logic [FR_W-1:0] frame_bits(input logic [FR_W-1:0] data,
                                                 input logic [HW_W-1:0] hw_en,
                                                 input logic [HW_W-1:0] hw_in,
                                                 input logic [1:0]      grp);
    logic [FR_W-1:0] d;
    d = data;
    for (int i = 0; i < HW_W; i++)
      if (hw_en[i]) d[i] = hw_in[i];
    case (grp)
      2'b01:   return {d[LO_W-1:0], {HI_W{1'b0}}};
      2'b10:   return {d[FR_W-1:LO_W], {LO_W{1'b0}}};
      2'b11:   return d;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sled_regs.sv
module sled_regs
  import sled_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [4:0]      addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  input  logic            sw_take,
  output logic            sw_req,
  output logic            edge_fall,
  output logic [HW_W-1:0] hw_en,
  output logic            auto_en,
  output logic [3:0]      rate_sel,
  output logic [1:0]      grp,
  output logic [FR_W-1:0] data
);
  localparam logic [4:0]  OFF_CTL0 = 5'h00;
  localparam logic [4:0]  OFF_CTL1 = 5'h04;
  localparam logic [4:0]  OFF_DAT  = 5'h08;
  localparam logic [31:0] MASK0    = 32'h0700_0000;
  localparam logic [31:0] MASK1    = 32'hC780_0003;
  localparam logic [31:0] MASKD    = (32'd1 << FR_W) - 32'd1;

  logic [31:0] ctl0_q, ctl1_q, dat_q;
  wire  wr_ctl0 = wr && (addr == OFF_CTL0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0_q <= '0;
      ctl1_q <= '0;
      dat_q  <= '0;
    end else begin
      ctl0_q[31] <= (ctl0_q[31] & ~sw_take) | (wr_ctl0 & wdata[31]);
      if (wr_ctl0)                   ctl0_q[30:0] <= wdata[30:0] & MASK0[30:0];
      if (wr && addr == OFF_CTL1)    ctl1_q <= wdata & MASK1;
      if (wr && addr == OFF_DAT)     dat_q  <= wdata & MASKD;
    end
  end

  always_comb begin
    case (addr)
      OFF_CTL0: rdata = ctl0_q;
      OFF_CTL1: rdata = ctl1_q;
      OFF_DAT:  rdata = dat_q;
      default:  rdata = '0;
    endcase
  end

  assign sw_req    = ctl0_q[31];
  assign edge_fall = ctl0_q[26];
  assign hw_en     = ctl0_q[25:24];
  assign auto_en   = ctl1_q[31];
  assign rate_sel  = ctl1_q[26:23];
  assign grp       = ctl1_q[1:0];
  assign data      = dat_q[FR_W-1:0];

  // R2: an accepted request is gone next cycle unless re-requested
  a_r2_req_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_take && !(wr_ctl0 && wdata[31])) |=> !sw_req);
  // R9: a write to an unmapped offset leaves the data word alone
  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (addr == 5'h0C || addr == 5'h10)) |=> $stable(data));
endmodule

// File: rtl/sled_rate_timer.sv
module sled_rate_timer
  import sled_pkg::*;
#(
  parameter int unsigned CLK_HZ = 125_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] sel,
  output logic       tick
);
  localparam int CW = $clog2(CLK_HZ / 2 + 1);

  function automatic logic [CW-1:0] period_limit(input logic [3:0] s);
    return CW'(CLK_HZ / rate_hz(s) - 1);
  endfunction

  logic [CW-1:0] cnt;
  wire  wrap = (cnt >= period_limit(sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      cnt  <= wrap ? '0 : cnt + 1'b1;
      tick <= wrap;
    end
  end

  // R7: no periodic start while automatic mode is off
  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick);
endmodule

// File: rtl/sled_serializer.sv
module sled_serializer
  import sled_pkg::*;
#(
  parameter int unsigned SHIFT_HALF = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [FR_W-1:0]  frame,
  input  logic [LEN_W-1:0] nbits,
  input  logic             edge_cfg,
  output logic             busy,
  output logic             sclk_o,
  output logic             sdo_o,
  output logic             stb_o
);
  localparam int HCW = (SHIFT_HALF > 1) ? $clog2(SHIFT_HALF) : 1;

  sh_state_t        st;
  logic [HCW-1:0]   cnt;
  logic [LEN_W-1:0] left;
  logic [FR_W-1:0]  sh;
  logic             edge_q;

  wire last_half = (cnt == HCW'(SHIFT_HALF - 1));
  wire shift_evt = (st == SH_ACT) && last_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SH_IDLE; cnt <= '0; left <= '0; sh <= '0; edge_q <= 1'b0;
    end else begin
      case (st)
        SH_IDLE: begin
          edge_q <= edge_cfg;
          if (start) begin
            st <= SH_SETUP; cnt <= '0; left <= nbits; sh <= frame;
          end
        end
        SH_SETUP: begin
          cnt <= last_half ? '0 : cnt + 1'b1;
          if (last_half) st <= SH_ACT;
        end
        SH_ACT: begin
          cnt <= last_half ? '0 : cnt + 1'b1;
          if (shift_evt) begin
            if (left == LEN_W'(1)) st <= SH_STORE;
            else begin
              st   <= SH_SETUP;
              left <= left - 1'b1;
              sh   <= sh << 1;
            end
          end
        end
        default: begin
          cnt <= last_half ? '0 : cnt + 1'b1;
          if (last_half) st <= SH_IDLE;
        end
      endcase
    end
  end

  assign busy   = (st != SH_IDLE);
  assign sclk_o = edge_q ^ (st == SH_ACT);
  assign sdo_o  = sh[FR_W-1];
  assign stb_o  = (st == SH_STORE);

  // R3: the top never starts a frame over one in flight
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R5: a start always carries at least one bit
  a_r5_nonempty_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (nbits != '0));
  // R3: data holds through the whole active clock phase
  a_r3_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SH_ACT) |-> $stable(sdo_o));
endmodule

// File: rtl/sled_shift_ctrl.sv
module sled_shift_ctrl
  import sled_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 125_000_000,
  parameter int unsigned SHIFT_HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [1:0]  hw_src,
  output logic        led_sclk,
  output logic        led_sdo,
  output logic        led_stb
);
  logic            sw_req, edge_fall, auto_en, tick, busy;
  logic [HW_W-1:0] hw_en;
  logic [3:0]      rate_sel;
  logic [1:0]      grp;
  logic [FR_W-1:0] data;

  wire sw_take = sw_req & ~busy;
  wire start   = (sw_take | (tick & ~busy)) & (grp != 2'b00);

  sled_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .sw_take(sw_take),
    .sw_req(sw_req), .edge_fall(edge_fall), .hw_en(hw_en),
    .auto_en(auto_en), .rate_sel(rate_sel), .grp(grp), .data(data)
  );

  sled_rate_timer #(.CLK_HZ(CLK_HZ)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(auto_en), .sel(rate_sel), .tick(tick)
  );

  sled_serializer #(.SHIFT_HALF(SHIFT_HALF)) u_ser (
    .clk(clk), .rst_n(rst_n), .start(start),
    .frame(frame_bits(data, hw_en, hw_src, grp)),
    .nbits(frame_len(grp)), .edge_cfg(edge_fall), .busy(busy),
    .sclk_o(led_sclk), .sdo_o(led_sdo), .stb_o(led_stb)
  );
endmodule

// File: tb/sim_sled_shift_ctrl.sv
`timescale 1ns/1ps
module sim_sled_shift_ctrl;
  localparam int unsigned HZ = 1000;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [1:0]  hw_src = '0;
  logic led_sclk, led_sdo, led_stb;

  sled_shift_ctrl #(.CLK_HZ(HZ), .SHIFT_HALF(1)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_src(hw_src),
    .led_sclk(led_sclk), .led_sdo(led_sdo), .led_stb(led_stb)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  logic mdl_fall = 1'b0;
  logic [23:0] sr_r = '0, sr_f = '0, lat = '0;
  int nsh_r = 0, nsh_f = 0, nst = 0;

  // external chain model
  always @(posedge led_sclk) if (!mdl_fall) begin sr_r = {sr_r[22:0], led_sdo}; nsh_r++; end
  always @(negedge led_sclk) if (mdl_fall)  begin sr_f = {sr_f[22:0], led_sdo}; nsh_f++; end
  always @(posedge led_stb) begin lat = mdl_fall ? sr_f : sr_r; nst++; end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic bwr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1; bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_store(input int t0);
    for (int k = 0; k < 600 && nst == t0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic int shifts();
    return mdl_fall ? nsh_f : nsh_r;
  endfunction

  // {grp, edge, hw_en, hw_in, data, expected frame, length}
  localparam logic [59:0] VECS [6] = '{
    {2'b11, 1'b0, 2'b00, 2'b00, 24'hA5C396, 24'hA5C396, 5'd24},
    {2'b01, 1'b1, 2'b00, 2'b00, 24'h123456, 24'h003456, 5'd16},
    {2'b10, 1'b0, 2'b00, 2'b00, 24'hF0E1D2, 24'h0000F0, 5'd8},
    {2'b11, 1'b1, 2'b11, 2'b10, 24'h000000, 24'h000002, 5'd24},
    {2'b01, 1'b0, 2'b01, 2'b01, 24'hFFFFFE, 24'h00FFFF, 5'd16},
    {2'b11, 1'b1, 2'b10, 2'b00, 24'h800003, 24'h800001, 5'd24}
  };

  initial begin
    logic [31:0] r;
    int s0, t0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    brd(5'h00, r); check("R1 ctl0", r, 0);
    brd(5'h04, r); check("R1 ctl1", r, 0);
    brd(5'h08, r); check("R1 data", r, 0);
    check("R1 pins", {29'b0, led_sclk, led_sdo, led_stb}, 0);

    for (int i = 0; i < 6; i++) begin
      logic [59:0] v;
      logic [23:0] msk;
      v = VECS[i];
      mdl_fall = v[57];
      hw_src   = v[54:53];
      bwr(5'h04, {30'b0, v[59:58]});
      bwr(5'h08, {8'b0, v[52:29]});
      bwr(5'h00, {5'b0, v[57], v[56:55], 24'b0});
      repeat (4) @(negedge clk);
      check("R4 idle level", {31'b0, led_sclk}, {31'b0, v[57]});
      s0 = shifts(); t0 = nst;
      bwr(5'h00, {1'b1, 4'b0, v[57], v[56:55], 24'b0});
      brd(5'h00, r); check("R2 request pending", {31'b0, r[31]}, 1);
      wait_store(t0);
      msk = 24'((32'd1 << v[4:0]) - 1);
      check("R3/R5 shift count", 32'(shifts() - s0), 32'(v[4:0]));
      check("R3/R6 latched frame", {8'b0, lat & msk}, {8'b0, v[28:5]});
      check("R3 one store", 32'(nst - t0), 1);
      brd(5'h00, r); check("R2 self clear", {31'b0, r[31]}, 0);
    end

    // R8: data written during a shift waits for the next update
    mdl_fall = 1'b0; hw_src = 2'b00;
    bwr(5'h04, 32'h3);
    bwr(5'h00, 32'h0);
    bwr(5'h08, 32'h5A5A5A);
    repeat (4) @(negedge clk);
    t0 = nst;
    bwr(5'h00, 32'h8000_0000);
    repeat (10) @(negedge clk);
    bwr(5'h08, 32'hC3C3C3);
    wait_store(t0);
    check("R8 old data shifted", {8'b0, lat}, 32'h5A5A5A);
    t0 = nst;
    bwr(5'h00, 32'h8000_0000);
    wait_store(t0);
    check("R8 new data next", {8'b0, lat}, 32'hC3C3C3);

    // R5: no group enabled -> no activity, request still clears
    bwr(5'h04, 32'h0);
    s0 = nsh_r; t0 = nst;
    bwr(5'h00, 32'h8000_0000);
    repeat (60) @(negedge clk);
    check("R5 no shifts", 32'(nsh_r - s0), 0);
    check("R5 no store", 32'(nst - t0), 0);
    brd(5'h00, r); check("R5 request cleared", {31'b0, r[31]}, 0);

    // R7: periodic updates at the selected rate
    foreach (VECS[j]) if (j < 3) begin
      logic [3:0] rs;
      int p;
      rs = (j == 0) ? 4'd0 : (j == 1) ? 4'd1 : 4'd7;
      p  = HZ / ((rs == 0) ? 2 : (rs == 1) ? 4 : 10);
      t0 = nst;
      bwr(5'h04, {2'b10, 3'b0, rs, 21'b0, 2'b11});
      repeat (3 * p + 60) @(negedge clk);
      check($sformatf("R7 rate sel %0d stores", rs), 32'(nst - t0), 3);
      bwr(5'h04, 32'h3);
      repeat (120) @(negedge clk);
    end

    // R9: unmapped offsets read zero and writes change nothing
    bwr(5'h0C, 32'hFFFF_FFFF);
    bwr(5'h10, 32'hFFFF_FFFF);
    brd(5'h0C, r); check("R9 offset 0x0C", r, 0);
    brd(5'h10, r); check("R9 offset 0x10", r, 0);
    brd(5'h08, r); check("R9 data kept", r, 32'hC3C3C3);
    brd(5'h04, r); check("R9 ctl1 kept", r, 32'h3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule